// File: doc/BRIEF.md
# Four-Channel Delayed Pulse Burst Generator

This block turns one trigger event into four independent pulse bursts. Each channel has its own programmed period, pulse count, high width and delay. The delay is split into two parts. The upper bits are a coarse count of clock cycles that the block waits. The low bits are a fine code that the block drives out to an external programmable delay line, which adds a sub-cycle offset in steps of 0.25 ns. This gives a wide delay range together with fine resolution.

Configuration is written through a simple register write port into staged registers. A channel copies its staged values into its own working registers only when a burst is accepted, so a write made during a burst takes effect at the next trigger. A burst can be started by a rising edge on an asynchronous external pin or by a write to the control register. When both arrive in the same cycle, the external source wins.

Each channel is a four-state machine. `CH_IDLE` goes to `CH_DELAY` when a trigger is accepted and the channel's configuration is valid. `CH_DELAY` goes to `CH_HIGH` when the coarse count runs out. `CH_HIGH` goes to `CH_LOW` at the end of the high width, or back to `CH_IDLE` after the final pulse. `CH_LOW` goes to `CH_HIGH` at the end of the period.

Top module: `quad_delay_pulser`

## Requirements
- R1: After reset, all pulse outputs, fine codes, `busy_o`, `miss_o`, `src_ext_o` and `cfg_err_o` are 0, and all staged registers are 0.
- R2: Write addresses: bit 4 = 0 selects channel bits[3:2] and field bits[1:0] (0 period, 1 pulse count, 2 high width, 3 delay). Address 0x10 is control: data bit0 = software trigger, bit1 = clear miss flag. The coarse delay C is delay >> 3. A channel's first pulse is high in the cycle that begins C+1 clock edges after the accepting edge.
- R3: Each pulse is high for exactly W cycles. Rising edges are P cycles apart. The channel emits exactly N pulses per burst.
- R4: The fine code output of a channel equals delay[2:0]. It is updated at the accepting edge and held unchanged through the burst.
- R5: A control write with bit0 set is accepted at the edge where it is written. A rising edge on `ext_trig_i` passes two synchronizer flops and is accepted at the third clock edge after the pin rises.
- R6: If an external edge and a software trigger are accepted in the same cycle, only one burst starts and `src_ext_o` = 1. A software-only trigger sets `src_ext_o` = 0.
- R7: A trigger that arrives while `busy_o` = 1 does not alter the running bursts and sets the sticky `miss_o`. A control write with bit1 set clears `miss_o`.
- R8: A channel with pulse count 0 emits no pulses and does not hold `busy_o` high.
- R9: A channel with nonzero count and with width 0 or width ≥ period shows its `cfg_err_o` bit = 1 and emits no pulses when triggered.
- R10: A configuration write made during a burst leaves that burst unchanged and takes effect at the next accepted trigger.
- R11: `busy_o` rises at the accepting edge if any channel is valid. It falls at the same edge as the final pulse of the last channel to finish, and pulses never appear while `busy_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 16 | Register write data |
| ext_trig_i | input | 1 | Asynchronous external trigger, rising edge |
| pulse_o | output | 4 | Pulse output per channel |
| fine_o | output | 12 | Fine delay code, 3 bits per channel, channel 0 in the low bits |
| busy_o | output | 1 | A burst is running |
| miss_o | output | 1 | Sticky: a trigger was ignored during a burst |
| src_ext_o | output | 1 | Source of the last accepted trigger, 1 = external |
| cfg_err_o | output | 4 | Per-channel invalid width/period setting |

## Verification
A channel machine stuck in or skipping `CH_DELAY` shows up as a first rising edge on the wrong cycle, within C+2 cycles of the trigger. A corrupted width or period counter shows up as a wrong high-length or rise spacing, by the second pulse at the latest. Wrong trigger arbitration shows at `src_ext_o` or `miss_o` in the cycle after the accepting edge, or as an extra burst a period later. A working register that is not frozen during the burst, or a fine code that is not held, shows up as a pulse count or fine code that differs from the values staged before the trigger.

// File: rtl/qdp_pkg.sv
package qdp_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_DELAY = 2'd1,
        CH_HIGH  = 2'd2,
        CH_LOW   = 2'd3
    } ch_state_e;

    localparam logic [1:0] FLD_PERIOD = 2'd0;
    localparam logic [1:0] FLD_COUNT  = 2'd1;
    localparam logic [1:0] FLD_WIDTH  = 2'd2;
    localparam logic [1:0] FLD_DELAY  = 2'd3;

endpackage

// File: rtl/qdp_sync_edge.sv
module qdp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-1:0], async_i};
        end
    end

    assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];

endmodule

// File: rtl/qdp_cfg_bank.sv
module qdp_cfg_bank
    import qdp_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int PER_W  = 16,
    parameter int CNT_W  = 8,
    parameter int DLY_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic [NCH*PER_W-1:0]  period_o,
    output logic [NCH*CNT_W-1:0]  count_o,
    output logic [NCH*PER_W-1:0]  width_o,
    output logic [NCH*DLY_W-1:0]  delay_o,
    output logic [NCH-1:0]        cfg_err_o
);

    localparam int CH_W = ADDR_W - 3;

    logic             bank_sel;
    logic [CH_W-1:0]  ch_sel;
    logic [1:0]       fld_sel;

    assign bank_sel = wr_en_i && !wr_addr_i[ADDR_W-1];
    assign ch_sel   = wr_addr_i[ADDR_W-2:2];
    assign fld_sel  = wr_addr_i[1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [PER_W-1:0] per_q;
        logic [CNT_W-1:0] cnt_q;
        logic [PER_W-1:0] wid_q;
        logic [DLY_W-1:0] dly_q;
        logic             hit;

        assign hit = bank_sel && (ch_sel == CH_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                per_q <= '0;
                cnt_q <= '0;
                wid_q <= '0;
                dly_q <= '0;
            end else if (hit) begin
                unique case (fld_sel)
                    FLD_PERIOD: per_q <= wr_data_i[PER_W-1:0];
                    FLD_COUNT:  cnt_q <= wr_data_i[CNT_W-1:0];
                    FLD_WIDTH:  wid_q <= wr_data_i[PER_W-1:0];
                    FLD_DELAY:  dly_q <= wr_data_i[DLY_W-1:0];
                    default:    ;
                endcase
            end
        end

        assign period_o[g*PER_W +: PER_W] = per_q;
        assign count_o[g*CNT_W +: CNT_W]  = cnt_q;
        assign width_o[g*PER_W +: PER_W]  = wid_q;
        assign delay_o[g*DLY_W +: DLY_W]  = dly_q;
        assign cfg_err_o[g] = (cnt_q != '0) && ((wid_q == '0) || (wid_q >= per_q));
    end

endmodule

// File: rtl/qdp_channel.sv
module qdp_channel
    import qdp_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int CNT_W  = 8,
    parameter int DLY_W  = 16,
    parameter int FINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [PER_W-1:0]  width_i,
    input  logic [DLY_W-1:0]  delay_i,
    output logic              pulse_o,
    output logic [FINE_W-1:0] fine_o,
    output logic              busy_o
);

    localparam int CRS_W = DLY_W - FINE_W;
    localparam int TMR_W = (PER_W > CRS_W) ? PER_W : CRS_W;

    ch_state_e        state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] wid_q;
    logic [FINE_W-1:0] fine_q;
    logic             pulse_q;
    logic             cfg_ok;
    logic             launch;

    assign cfg_ok = (count_i != '0) && (width_i != '0) && (width_i < period_i);
    assign launch = (state_q == CH_IDLE) && start_i && cfg_ok;

    // next-state logic
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        left_d  = left_q;
        unique case (state_q)
            CH_IDLE: begin
                if (launch) begin
                    state_d = CH_DELAY;
                    tmr_d   = TMR_W'(delay_i[DLY_W-1:FINE_W]);
                    left_d  = count_i;
                end
            end
            CH_DELAY: begin
                if (tmr_q == '0) begin
                    state_d = CH_HIGH;
                    tmr_d   = TMR_W'(wid_q) - TMR_W'(1);
                end else begin
                    tmr_d = tmr_q - TMR_W'(1);
                end
            end
            CH_HIGH: begin
                if (tmr_q == '0) begin
                    if (left_q == CNT_W'(1)) begin
                        state_d = CH_IDLE;
                    end else begin
                        state_d = CH_LOW;
                        tmr_d   = TMR_W'(per_q - wid_q) - TMR_W'(1);
                    end
                    left_d = left_q - CNT_W'(1);
                end else begin
                    tmr_d = tmr_q - TMR_W'(1);
                end
            end
            CH_LOW: begin
                if (tmr_q == '0) begin
                    state_d = CH_HIGH;
                    tmr_d   = TMR_W'(wid_q) - TMR_W'(1);
                end else begin
                    tmr_d = tmr_q - TMR_W'(1);
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // state register and working copy of the configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            tmr_q   <= '0;
            left_q  <= '0;
            per_q   <= '0;
            wid_q   <= '0;
            fine_q  <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            left_q  <= left_d;
            if (launch) begin
                per_q  <= period_i;
                wid_q  <= width_i;
                fine_q <= delay_i[FINE_W-1:0];
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= (state_d == CH_HIGH);
        end
    end

    assign pulse_o = pulse_q;
    assign fine_o  = fine_q;
    assign busy_o  = (state_q != CH_IDLE);

endmodule

// File: rtl/quad_delay_pulser.sv
module quad_delay_pulser
    import qdp_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = $clog2(NCH) + 3,
    parameter int DATA_W = 16,
    parameter int PER_W  = 16,
    parameter int CNT_W  = 8,
    parameter int DLY_W  = 16,
    parameter int FINE_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic                  ext_trig_i,
    output logic [NCH-1:0]        pulse_o,
    output logic [NCH*FINE_W-1:0] fine_o,
    output logic                  busy_o,
    output logic                  miss_o,
    output logic                  src_ext_o,
    output logic [NCH-1:0]        cfg_err_o
);

    logic [NCH*PER_W-1:0] period_w;
    logic [NCH*CNT_W-1:0] count_w;
    logic [NCH*PER_W-1:0] width_w;
    logic [NCH*DLY_W-1:0] delay_w;
    logic [NCH-1:0]       ch_busy;
    logic                 ext_rise;
    logic                 ctrl_wr;
    logic                 sw_req;
    logic                 clr_req;
    logic                 trig_any;
    logic                 trig_accept;
    logic                 miss_q;
    logic                 src_q;

    qdp_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_trig_i),
        .rise_o  (ext_rise)
    );

    qdp_cfg_bank #(
        .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PER_W(PER_W), .CNT_W(CNT_W), .DLY_W(DLY_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .period_o  (period_w),
        .count_o   (count_w),
        .width_o   (width_w),
        .delay_o   (delay_w),
        .cfg_err_o (cfg_err_o)
    );

    assign ctrl_wr     = wr_en_i && wr_addr_i[ADDR_W-1];
    assign sw_req      = ctrl_wr && wr_data_i[0];
    assign clr_req     = ctrl_wr && wr_data_i[1];
    assign trig_any    = ext_rise || sw_req;
    assign busy_o      = |ch_busy;
    assign trig_accept = trig_any && !busy_o;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        qdp_channel #(
            .PER_W(PER_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .FINE_W(FINE_W)
        ) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (trig_accept),
            .period_i (period_w[g*PER_W +: PER_W]),
            .count_i  (count_w[g*CNT_W +: CNT_W]),
            .width_i  (width_w[g*PER_W +: PER_W]),
            .delay_i  (delay_w[g*DLY_W +: DLY_W]),
            .pulse_o  (pulse_o[g]),
            .fine_o   (fine_o[g*FINE_W +: FINE_W]),
            .busy_o   (ch_busy[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_q <= 1'b0;
            src_q  <= 1'b0;
        end else begin
            if (trig_any && busy_o) begin
                miss_q <= 1'b1;
            end else if (clr_req) begin
                miss_q <= 1'b0;
            end
            if (trig_accept) begin
                src_q <= ext_rise;
            end
        end
    end

    assign miss_o    = miss_q;
    assign src_ext_o = src_q;

endmodule

// File: rtl/qdp_checker.sv
module qdp_checker #(
    parameter int NCH    = 4,
    parameter int FINE_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH-1:0]        pulse_o,
    input logic [NCH*FINE_W-1:0] fine_o,
    input logic                  busy_o,
    input logic                  miss_o,
    input logic [NCH-1:0]        cfg_err_o,
    input logic [NCH-1:0]        ch_busy,
    input logic                  trig_accept
);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (pulse_o == '0));

    assert_miss_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_o) |-> $past(busy_o));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_fine_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_busy[g] && $past(ch_busy[g])) |-> $stable(fine_o[g*FINE_W +: FINE_W]));

        assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(trig_accept) && $past(cfg_err_o[g])) |-> !ch_busy[g]);

        assert_pulse_in_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[g] |-> ch_busy[g]);
    end

endmodule

bind quad_delay_pulser qdp_checker #(.NCH(NCH), .FINE_W(FINE_W)) i_qdp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_o     (pulse_o),
    .fine_o      (fine_o),
    .busy_o      (busy_o),
    .miss_o      (miss_o),
    .cfg_err_o   (cfg_err_o),
    .ch_busy     (ch_busy),
    .trig_accept (trig_accept)
);

// File: tb/test_quad_delay_pulser.sv
module test_quad_delay_pulser;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        ext_trig_i = 1'b0;
    logic [3:0]  pulse_o;
    logic [11:0] fine_o;
    logic        busy_o;
    logic        miss_o;
    logic        src_ext_o;
    logic [3:0]  cfg_err_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int first_rise [4];
    int rise_cnt   [4];
    int width1     [4];
    int per1       [4];
    logic [2:0] fine0 [4];
    int busy_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_delay_pulser i_quad_delay_pulser (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .ext_trig_i (ext_trig_i),
        .pulse_o    (pulse_o),
        .fine_o     (fine_o),
        .busy_o     (busy_o),
        .miss_o     (miss_o),
        .src_ext_o  (src_ext_o),
        .cfg_err_o  (cfg_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic cfg_ch(input int ch, input int per, input int cnt, input int wid, input int dly);
        wr(5'((ch << 2) | 0), 16'(per));
        wr(5'((ch << 2) | 1), 16'(cnt));
        wr(5'((ch << 2) | 2), 16'(wid));
        wr(5'((ch << 2) | 3), 16'(dly));
    endtask

    // leaves the bench at the negedge after the accepting edge (k = 0)
    task automatic sw_fire();
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 5'h10; wr_data_i = 16'h0001;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic ext_fire(input bit with_sw);
        @(negedge clk);
        ext_trig_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (with_sw) begin
            wr_en_i = 1'b1; wr_addr_i = 5'h10; wr_data_i = 16'h0001;
        end
        @(negedge clk);
        wr_en_i = 1'b0;
        ext_trig_i = 1'b0;
    endtask

    task automatic capture(input int ncyc, input int inj_k, input logic [4:0] ia, input logic [15:0] idat);
        logic [3:0] prev;
        prev = '0;
        busy_last = -1;
        for (int ch = 0; ch < 4; ch++) begin
            first_rise[ch] = -1; rise_cnt[ch] = 0; width1[ch] = 0; per1[ch] = -1;
        end
        for (int k = 0; k < ncyc; k++) begin
            if (k == 0) for (int ch = 0; ch < 4; ch++) fine0[ch] = fine_o[ch*3 +: 3];
            for (int ch = 0; ch < 4; ch++) begin
                if (pulse_o[ch] && !prev[ch]) begin
                    rise_cnt[ch]++;
                    if (rise_cnt[ch] == 1) first_rise[ch] = k;
                    else if (rise_cnt[ch] == 2) per1[ch] = k - first_rise[ch];
                end
                if (pulse_o[ch] && rise_cnt[ch] == 1) width1[ch]++;
            end
            prev = pulse_o;
            if (busy_o) busy_last = k;
            if (k == inj_k) begin
                wr_en_i = 1'b1; wr_addr_i = ia; wr_data_i = idat;
            end else begin
                wr_en_i = 1'b0;
            end
            @(negedge clk);
        end
        wr_en_i = 1'b0;
    endtask

    task automatic chk_ch(input int ch, input int rise, input int n, input int w, input int p,
                          input int f, input string req);
        chk(rise_cnt[ch] == n, {req, " pulse count"}, rise_cnt[ch], n);
        if (n > 0) begin
            chk(first_rise[ch] == rise, {req, " first rise"}, first_rise[ch], rise);
            chk(width1[ch] == w, {req, " width"}, width1[ch], w);
            chk(int'(fine0[ch]) == f, {req, " fine code"}, int'(fine0[ch]), f);
        end
        if (n > 1) chk(per1[ch] == p, {req, " period"}, per1[ch], p);
    endtask

    task automatic t_reset();
        chk(pulse_o == 4'h0, "R1 pulse", int'(pulse_o), 0);
        chk(fine_o == 12'h0, "R1 fine", int'(fine_o), 0);
        chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        chk(miss_o == 1'b0, "R1 miss", int'(miss_o), 0);
        chk(src_ext_o == 1'b0, "R1 src", int'(src_ext_o), 0);
        chk(cfg_err_o == 4'h0, "R1 cfg_err", int'(cfg_err_o), 0);
    endtask

    task automatic t_sw_burst();
        cfg_ch(0, 10, 3, 4, 5*8 + 2);
        cfg_ch(1, 6, 2, 1, 0*8 + 7);
        cfg_ch(2, 20, 1, 19, 12*8 + 0);
        cfg_ch(3, 8, 4, 2, 3*8 + 5);
        sw_fire();
        capture(80, -1, '0, '0);
        chk_ch(0, 6, 3, 4, 10, 2, "R2 R3 R4 R5 ch0");
        chk_ch(1, 1, 2, 1, 6, 7, "R2 R3 R4 ch1");
        chk_ch(2, 13, 1, 19, 0, 0, "R2 R3 R4 ch2");
        chk_ch(3, 4, 4, 2, 8, 5, "R2 R3 R4 ch3");
        chk(busy_last == 31, "R11 busy end", busy_last, 31);
        chk(fine_o == {3'd5, 3'd0, 3'd7, 3'd2}, "R4 fine held after burst", int'(fine_o), 12'o5072);
        chk(src_ext_o == 1'b0, "R6 sw source", int'(src_ext_o), 0);
    endtask

    task automatic t_ext_and_disable();
        cfg_ch(0, 7, 2, 3, 4*8 + 1);
        wr(5'h05, 16'd0);
        wr(5'h09, 16'd0);
        wr(5'h0D, 16'd0);
        ext_fire(1'b0);
        capture(40, -1, '0, '0);
        chk_ch(0, 5, 2, 3, 7, 1, "R5 ext ch0");
        for (int ch = 1; ch < 4; ch++) chk_ch(ch, 0, 0, 0, 0, 0, "R8 disabled");
        chk(busy_last == 14, "R8 R11 busy only ch0", busy_last, 14);
        chk(src_ext_o == 1'b1, "R6 ext source", int'(src_ext_o), 1);
    endtask

    task automatic t_priority();
        sw_fire();
        capture(30, -1, '0, '0);
        chk(src_ext_o == 1'b0, "R6 src after sw", int'(src_ext_o), 0);
        ext_fire(1'b1);
        capture(40, -1, '0, '0);
        chk_ch(0, 5, 2, 3, 7, 1, "R6 single burst");
        chk(src_ext_o == 1'b1, "R6 ext wins", int'(src_ext_o), 1);
        chk(miss_o == 1'b0, "R6 no miss", int'(miss_o), 0);
    endtask

    task automatic t_missed();
        sw_fire();
        capture(40, 3, 5'h10, 16'h0001);
        chk_ch(0, 5, 2, 3, 7, 1, "R7 burst unchanged");
        chk(busy_last == 14, "R7 no restart", busy_last, 14);
        chk(miss_o == 1'b1, "R7 miss set", int'(miss_o), 1);
        wr(5'h10, 16'h0002);
        chk(miss_o == 1'b0, "R7 miss cleared", int'(miss_o), 0);
        chk(busy_o == 1'b0, "R7 clear not a trigger", int'(busy_o), 0);
    endtask

    task automatic t_shadow();
        sw_fire();
        capture(40, 3, 5'h01, 16'd5);
        chk_ch(0, 5, 2, 3, 7, 1, "R10 running burst");
        sw_fire();
        capture(60, -1, '0, '0);
        chk_ch(0, 5, 5, 3, 7, 1, "R10 next burst");
        chk(busy_last == 35, "R10 R11 busy end", busy_last, 35);
    endtask

    task automatic t_cfg_err();
        cfg_ch(0, 7, 2, 3, 4*8 + 1);
        cfg_ch(1, 5, 2, 5, 1*8 + 3);
        cfg_ch(2, 5, 2, 0, 1*8 + 4);
        @(negedge clk);
        chk(cfg_err_o == 4'b0110, "R9 flags", int'(cfg_err_o), 6);
        sw_fire();
        capture(40, -1, '0, '0);
        chk_ch(1, 0, 0, 0, 0, 0, "R9 ch1 silent");
        chk_ch(2, 0, 0, 0, 0, 0, "R9 ch2 silent");
        chk_ch(0, 5, 2, 3, 7, 1, "R9 ch0 runs");
        chk(busy_last == 14, "R9 busy ch0 only", busy_last, 14);
        wr(5'h05, 16'd0);
        chk(cfg_err_o == 4'b0100, "R9 R8 count0 clears flag", int'(cfg_err_o), 4);
    endtask

    task automatic t_all_off();
        wr(5'h01, 16'd0);
        sw_fire();
        capture(20, -1, '0, '0);
        chk(busy_last == -1, "R8 R11 no busy", busy_last, -1);
        chk(rise_cnt[0] + rise_cnt[1] + rise_cnt[2] + rise_cnt[3] == 0, "R8 no pulses",
            rise_cnt[0] + rise_cnt[1] + rise_cnt[2] + rise_cnt[3], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_burst();
        t_ext_and_disable();
        t_priority();
        t_missed();
        t_shadow();
        t_cfg_err();
        t_all_off();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule